// File: doc/BRIEF.md
# Fixed-Key Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus. A down-counter runs on the peripheral clock. When it runs out, the block raises a reset request. Software holds the request off by writing a fixed pair of key words to a service register. Each correct pair copies the programmed timeout back into the counter.

The timeout register does not touch a running count. It only reaches the counter when the watchdog is enabled, or when a service completes. The counter can be read back only while the watchdog is disabled. Two control bits decide whether counting pauses while the debug-halt input is high and while the low-power-stop input is high. A lock bit freezes the configuration until the next system reset.

The counter is a three-state machine:

- `CNT_OFF` moves to `CNT_RUN` on the *arm* transition, which is a control write that sets the enable bit while it was clear.
- `CNT_RUN` returns to `CNT_OFF` on the *halt* transition, which happens when enable is cleared.
- `CNT_RUN` moves to `CNT_FIRED` on the *expire* transition, when the count runs out.
- `CNT_FIRED` is left only by system reset.

The key checker is a two-state machine:

- `KEY_IDLE` moves to `KEY_HALF` on the *first-key* transition.
- `KEY_HALF` returns to `KEY_IDLE` on the *service* transition (second key), on a *mismatch*, or on *disarm*.
- `KEY_HALF` stays in `KEY_HALF` on a repeated first key.

Top module: `wdg_timer`

Register map (byte addresses):

| Address | Register | Access |
|---------|----------|--------|
| 0x0 | Control | read/write |
| 0x4 | Timeout | read/write |
| 0x8 | Service | write only, reads 0 |
| 0xC | Count view | read only |

Control register fields:

| Bits | Field |
|------|-------|
| 0 | enable |
| 1 | freeze-in-debug |
| 2 | pause-in-stop |
| 4 | lock |
| 10:9 | service mode |

## Requirements
- R1: After reset, Control reads 0, Timeout reads the TO_RESET parameter value, Count view reads 0 and `wdt_reset_req` is low.
- R2: A Control write that sets bit 0 while it was clear loads the counter from Timeout. With no pause and no service, `wdt_reset_req` rises exactly T clock edges after that write edge, for a timeout T of at least 1.
- R3: A Timeout write during counting leaves the running count unchanged, and the value reads back at once. The new value takes effect at the next service.
- R4: A write of 0x0000A602 to Service followed by a write of 0x0000B480 to Service reloads the counter. The reset request then rises T edges after the second write. Writes to other addresses between the two keys do not break the sequence.
- R5: Any other value written to Service between the keys cancels the sequence. A repeated 0x0000A602 counts as a fresh first key.
- R6: Service writes while bit 0 is clear have no effect: the Count view is unchanged and no partial sequence survives the enable.
- R7: Count view returns the count while bit 0 is clear. While bit 0 is set, it keeps the value captured before enabling.
- R8: Clearing bit 0 halts the count, and it stays constant while disabled. Setting bit 0 again reloads from Timeout.
- R9: With bit 1 set, the count pauses on every edge where `dbg_halt` is high. With bit 1 clear, `dbg_halt` is ignored.
- R10: With bit 2 set, the count pauses on every edge where `lp_stop` is high. With bit 2 clear, `lp_stop` is ignored.
- R11: Once bit 4 is written to 1, later writes to Control and Timeout are ignored until system reset.
- R12: `wdt_reset_req` stays high once raised, whatever is written, until `rst_n` is asserted.
- R13: Field 10:9 reads back as written. Service keys are honoured only when it is 00, the reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data |
| dbg_halt | input | 1 | Debug-halt indication |
| lp_stop | input | 1 | Low-power-stop indication |
| wdt_reset_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with CNT_W = 12 and TO_RESET = 40. This keeps every expiry within a few dozen cycles, so each timeout from 1 to 12 can be run to expiry. Each service offset in a window can be tried, and each pause length can be measured exactly. The short counter also lets the disabled readback be swept across several stop points, with the expected count worked out as the timeout minus the number of elapsed edges.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W   = 32;
    localparam int OFF_CTRL = 0;
    localparam int OFF_TMO  = 4;
    localparam int OFF_SVC  = 8;
    localparam int OFF_CNT  = 12;
    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_A602;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_B480;

    typedef struct packed {
        logic [1:0] mode;
        logic       lock;
        logic       stp;
        logic       frz;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {CNT_OFF, CNT_RUN, CNT_FIRED} cnt_state_t;
    typedef enum logic {KEY_IDLE, KEY_HALF} key_state_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ADDR_W = 4,
    parameter logic [CNT_W-1:0] TO_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  ctrl_t             wr_ctrl,
    input  logic [CNT_W-1:0]  wr_tmo,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt_view,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  tmo,
    output logic              en_load,
    output logic              svc_wr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(OFF_TMO);
    localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(OFF_SVC);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

    logic ctrl_wr, tmo_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL) && !ctrl.lock;
    assign tmo_wr  = wr_en && (wr_addr == A_TMO) && !ctrl.lock;
    assign en_load = ctrl_wr && wr_ctrl.en && !ctrl.en;
    assign svc_wr  = wr_en && (wr_addr == A_SVC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            tmo  <= TO_RESET;
        end else begin
            if (ctrl_wr) ctrl <= wr_ctrl;
            if (tmo_wr)  tmo  <= wr_tmo;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[0]    = ctrl.en;
            rd_data[1]    = ctrl.frz;
            rd_data[2]    = ctrl.stp;
            rd_data[4]    = ctrl.lock;
            rd_data[10:9] = ctrl.mode;
        end else if (rd_addr == A_TMO) begin
            rd_data = DATA_W'(tmo);
        end else if (rd_addr == A_CNT) begin
            rd_data = DATA_W'(cnt_view);
        end
    end

    // R11
    lock_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock |=> $stable(tmo));
    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock |=> (ctrl.lock && $stable(ctrl)));
endmodule

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_ok
);
    key_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= KEY_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (!armed) begin
            st_nx = KEY_IDLE;
        end else if (svc_wr) begin
            unique case (st)
                KEY_IDLE: st_nx = (svc_data == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
                KEY_HALF: st_nx = (svc_data == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_ok = armed && svc_wr && (st == KEY_HALF) && (svc_data == KEY_SECOND);
    end

    // R5
    key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && svc_wr && svc_data != KEY_FIRST) |=> (st == KEY_IDLE));
    // R6
    key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (st == KEY_IDLE));
endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             en_load,
    input  logic             svc_ok,
    input  logic             active,
    input  logic [CNT_W-1:0] tmo,
    output logic [CNT_W-1:0] cnt_view,
    output logic             run,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CNT_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            CNT_OFF: begin
                if (en_load) begin
                    cnt_nx = tmo;
                    st_nx  = CNT_RUN;
                end
            end
            CNT_RUN: begin
                if (en_load) begin
                    cnt_nx = tmo;
                end else if (!en) begin
                    st_nx = CNT_OFF;
                end else if (svc_ok) begin
                    cnt_nx = tmo;
                end else if (active) begin
                    if (cnt <= ONE) begin
                        cnt_nx = '0;
                        st_nx  = CNT_FIRED;
                    end else begin
                        cnt_nx = cnt - ONE;
                    end
                end
            end
            CNT_FIRED: begin
                st_nx = CNT_FIRED;
            end
            default: st_nx = CNT_FIRED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_view <= '0;
        else if (!en) cnt_view <= cnt;
    end

    always_comb begin
        run  = (st == CNT_RUN) && en;
        fire = (st == CNT_FIRED);
    end

    // R12
    fire_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> fire);
    // R2
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_load && st != CNT_FIRED) |=> (cnt == $past(tmo)));
    // R4
    svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && st == CNT_RUN && en) |=> (cnt == $past(tmo)));
    // R9, R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_RUN && en && !active && !svc_ok && !en_load) |=> $stable(cnt));
    // R7
    view_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cnt_view));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ADDR_W = 4,
    parameter logic [CNT_W-1:0] TO_RESET = CNT_W'(32'h0000_FFFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              dbg_halt,
    input  logic              lp_stop,
    output logic              wdt_reset_req
);
    ctrl_t            ctrl, wr_ctrl;
    logic [CNT_W-1:0] tmo, cnt_view;
    logic             en_load, svc_wr, svc_ok, run, fire, active, armed;

    always_comb begin
        wr_ctrl.en   = wr_data[0];
        wr_ctrl.frz  = wr_data[1];
        wr_ctrl.stp  = wr_data[2];
        wr_ctrl.lock = wr_data[4];
        wr_ctrl.mode = wr_data[10:9];
    end

    assign active = !(ctrl.frz && dbg_halt) && !(ctrl.stp && lp_stop);
    assign armed  = run && (ctrl.mode == 2'b00);
    assign wdt_reset_req = fire;

    wdg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .TO_RESET(TO_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_ctrl(wr_ctrl), .wr_tmo(wr_data[CNT_W-1:0]), .rd_addr(rd_addr),
        .cnt_view(cnt_view), .ctrl(ctrl), .tmo(tmo), .en_load(en_load),
        .svc_wr(svc_wr), .rd_data(rd_data)
    );

    wdg_key u_key (
        .clk(clk), .rst_n(rst_n), .armed(armed), .svc_wr(svc_wr),
        .svc_data(wr_data), .svc_ok(svc_ok)
    );

    wdg_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .en_load(en_load),
        .svc_ok(svc_ok), .active(active), .tmo(tmo), .cnt_view(cnt_view),
        .run(run), .fire(fire)
    );

    // R13
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode != 2'b00) |-> !svc_ok);
endmodule

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int TDEF = 40;
    localparam logic [3:0] A_CTRL = 4'h0, A_TMO = 4'h4, A_SVC = 4'h8, A_CNT = 4'hC;

    logic clk = 0, rst_n = 0, wr_en = 0, dbg_halt = 0, lp_stop = 0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic wdt_reset_req;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_timer #(.CNT_W(CW), .ADDR_W(4), .TO_RESET(CW'(TDEF))) u_wdg_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .lp_stop(lp_stop), .wdt_reset_req(wdt_reset_req)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic fire_at(input int d, input string rq);
        idle(d - 1);
        chk(rq, {31'b0, wdt_reset_req}, 32'd0);
        idle(1);
        chk(rq, {31'b0, wdt_reset_req}, 32'd1);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; dbg_halt = 0; lp_stop = 0;
        idle(2);
        rst_n = 1;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_TMO, v);  chk("R1 tmo", v, TDEF);
        rd(A_CNT, v);  chk("R1 cnt", v, 32'h0);
        chk("R1 req", {31'b0, wdt_reset_req}, 32'd0);

        // R2 expiry sweep, R12 sticky request
        for (int t = 1; t <= 12; t++) begin
            do_reset();
            wr(A_TMO, t);
            wr(A_CTRL, 32'h1);
            fire_at(t, "R2");
            wr(A_CTRL, 32'h0);
            wr(A_SVC, 32'h0000_A602);
            wr(A_SVC, 32'h0000_B480);
            idle(3);
            chk("R12 sticky", {31'b0, wdt_reset_req}, 32'd1);
        end
        do_reset();
        chk("R12 cleared", {31'b0, wdt_reset_req}, 32'd0);

        // R4 service at several offsets
        for (int k = 1; k <= 6; k++) begin
            do_reset();
            wr(A_TMO, 10);
            wr(A_CTRL, 32'h1);
            idle(k);
            wr(A_SVC, 32'h0000_A602);
            if (k % 2 == 1) wr(A_CNT, 32'h0000_1234);
            wr(A_SVC, 32'h0000_B480);
            fire_at(10, "R4");
        end

        // R5 broken and restarted sequences
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h1);
        wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_1234); wr(A_SVC, 32'h0000_B480);
        fire_at(7, "R5 broken");
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h1);
        wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_B480);
        fire_at(10, "R5 repeat first");

        // R3 timeout write while running
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h1); wr(A_TMO, 30);
        rd(A_TMO, v); chk("R3 tmo readback", v, 32'd30);
        fire_at(9, "R3 no change");
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h1); wr(A_TMO, 20);
        wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_B480);
        fire_at(20, "R3 next service");

        // R6 R7 R8 readback and disable
        for (int n = 0; n <= 5; n++) begin
            do_reset();
            wr(A_CTRL, 32'h1);
            idle(n);
            rd(A_CNT, v); chk("R7 frozen before", v, 32'd0);
            wr(A_CTRL, 32'h0);
            idle(1);
            rd(A_CNT, v); chk("R7 live", v, TDEF - (n + 1));
            idle(20);
            rd(A_CNT, v); chk("R8 halted", v, TDEF - (n + 1));
            wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_B480);
            idle(1);
            rd(A_CNT, v); chk("R6 disabled svc", v, TDEF - (n + 1));
            wr(A_SVC, 32'h0000_A602);
            wr(A_CTRL, 32'h1);
            wr(A_SVC, 32'h0000_B480);
            rd(A_CNT, v); chk("R7 stale", v, TDEF - (n + 1));
            fire_at(TDEF - 1, "R6 R8 reload");
        end

        // R9 debug freeze, R10 stop pause
        for (int p = 1; p <= 4; p++) begin
            do_reset();
            wr(A_TMO, 10); wr(A_CTRL, 32'h3);
            dbg_halt = 1; idle(p); dbg_halt = 0;
            fire_at(10, "R9 paused");
            do_reset();
            wr(A_TMO, 10); wr(A_CTRL, 32'h1);
            dbg_halt = 1; idle(p); dbg_halt = 0;
            fire_at(10 - p, "R9 ignored");
            do_reset();
            wr(A_TMO, 10); wr(A_CTRL, 32'h5);
            lp_stop = 1; idle(p); lp_stop = 0;
            fire_at(10, "R10 paused");
            do_reset();
            wr(A_TMO, 10); wr(A_CTRL, 32'h3);
            lp_stop = 1; idle(p); lp_stop = 0;
            fire_at(10 - p, "R10 ignored");
        end

        // R11 lock
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h11);
        wr(A_TMO, 50); wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R11 ctrl", v, 32'h11);
        rd(A_TMO, v);  chk("R11 tmo", v, 32'd10);
        fire_at(8, "R11 still running");

        // R13 mode field
        do_reset();
        wr(A_TMO, 10); wr(A_CTRL, 32'h201);
        rd(A_CTRL, v); chk("R13 readback", v, 32'h201);
        wr(A_SVC, 32'h0000_A602); wr(A_SVC, 32'h0000_B480);
        fire_at(8, "R13 keys ignored");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule